// File: doc/BRIEF.md
# EDH Packet CRC Regenerator

This block sits inline in a 10-bit standard-definition video word stream and rewrites error detection and handling (EDH) ancillary packets as they go by. Two CRC accumulators run over each field: one across the active-picture range and one across the full-field range. Each range is marked by a pair of start and end strobes from the timing logic upstream. The value each accumulator reaches at its end strobe is held. It is written into the next EDH packet that passes.

When insertion is enabled, the block replaces both CRC word triplets in the packet and forces their validity bits high. It then recomputes the packet checksum. Error-flag rewriting is a separate option with its own control. The two status outputs report the validity bits exactly as they arrived, so a downstream monitor can still see what the upstream link claimed. Every word leaves the block one clock after it enters. Words outside EDH packets are never altered.

Top module: `edh_crc_regen`

## Requirements
- R1: With `crc_ins_n_i` high, every output word equals the input word of the previous cycle, including all words of EDH packets.
- R2: A packet is recognised as the words 0x000, 0x3FF, 0x3FF followed by the identifier 0x1F4, then a block number word, a count word, 16 user words (UDW0..UDW15) and a checksum word. All words outside a recognised packet, including whole packets with any other identifier, are passed unchanged with one cycle of latency.
- R3: Each CRC uses the polynomial x^16+x^12+x^5+1 with a zero initial value. Bits 0 to 9 of each word are shifted in, LSB first, with the feedback taken from CRC bit 15. The CRC covers the words from the start-strobe word to the end-strobe word, both included. A range may be a single word. The result is held from the end word until the next end word, and it is the value inserted into any later packet.
- R4: When insertion is enabled, the active-picture CRC goes into UDW0..UDW2 and the full-field CRC into UDW3..UDW5. The first word of a triplet carries CRC bits 5:0 in word bits 7:2, the second carries bits 11:6 in bits 7:2, and the third carries bits 15:12 in bits 5:2.
- R5: In every inserted CRC word, bit 8 is the XOR of bits 7:0 and bit 9 is the inverse of bit 8. Bit 7 of UDW2 and UDW5 (the validity bit) is forced to 1. Bit 6 of those two words, and bits 1:0 of all six CRC words, are written as 0.
- R6: `ap_v_rx_o` and `ff_v_rx_o` take bit 7 of UDW2 and of UDW5 as received in EDH packets, whatever the insertion control. They hold their value at all other times.
- R7: When insertion is enabled, the checksum word is rewritten. Its bits 8:0 are the 9-bit sum of bits 8:0 of the outgoing identifier, block number, count and UDW0..UDW15 words, and bit 9 is the inverse of bit 8.
- R8: With `flag_upd_i` low, UDW6..UDW15 pass unchanged. UDW8..UDW15 always pass unchanged.
- R9: With insertion enabled and `flag_upd_i` high, UDW6 (active-picture flags) and UDW7 (full-field flags) are rewritten. Bit 2 becomes 1 exactly when the received validity bit was 1 and the received CRC differs from the held local CRC. Bit 3 becomes the OR of the received bits 3 and 2. Bits 8 and 9 are recomputed as in R5, and the other bits are kept.
- R10: During reset the output word and both status outputs are 0, and both held CRCs are zero until their first end strobe.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Word clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| din_i | input | 10 | Incoming video word |
| ap_start_i | input | 1 | First word of the active-picture CRC range |
| ap_end_i | input | 1 | Last word of the active-picture CRC range |
| ff_start_i | input | 1 | First word of the full-field CRC range |
| ff_end_i | input | 1 | Last word of the full-field CRC range |
| crc_ins_n_i | input | 1 | Low enables CRC and checksum insertion |
| flag_upd_i | input | 1 | High enables error-flag rewriting |
| dout_o | output | 10 | Outgoing video word, one cycle after input |
| ap_v_rx_o | output | 1 | Received active-picture validity bit |
| ff_v_rx_o | output | 1 | Received full-field validity bit |

## Verification
Several properties are checked on every cycle. Outside packets, and with insertion disabled, each output word must equal the previous input word. Each inserted CRC word must carry correct parity, with the validity bit set. Status outputs may change only after the triplet word that carries the validity bit. A held CRC may change only on an end strobe. The CRC values themselves, the checksum, flag rewriting against matching and mismatching received CRCs, and rejection of a packet with a foreign identifier can only be shown by the bench's scenarios. There, a behavioural model computes the expected words over synthetic fields with several range layouts.

// File: rtl/edh_crc_pkg.sv
package edh_crc_pkg;
    localparam int unsigned WORD_W = 10;
    localparam int unsigned CRC_W  = 16;
    localparam int unsigned SEG_W  = WORD_W - 4;
    localparam int unsigned SUM_W  = WORD_W - 1;
    localparam logic [CRC_W-1:0] CRC_POLY = 16'h1021;

    typedef enum logic [2:0] {
        P_IDLE, P_ADF1, P_ADF2, P_DID, P_DBN, P_DC, P_UDW, P_CS
    } pkt_state_e;

    // one 10-bit word shifted through the CRC register, LSB first
    function automatic logic [CRC_W-1:0] crc_step(input logic [CRC_W-1:0] c,
                                                  input logic [WORD_W-1:0] w);
        logic [CRC_W-1:0] r;
        logic fb;
        r = c;
        for (int i = 0; i < WORD_W; i++) begin
            fb = w[i] ^ r[CRC_W-1];
            r  = {r[CRC_W-2:0], 1'b0} ^ (fb ? CRC_POLY : '0);
        end
        return r;
    endfunction

    // add parity bit 8 and its inverse in bit 9
    function automatic logic [WORD_W-1:0] seal(input logic [WORD_W-3:0] b);
        return {~(^b), ^b, b};
    endfunction
endpackage

// File: rtl/edh_crc_acc.sv
module edh_crc_acc
    import edh_crc_pkg::*;
(
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WORD_W-1:0] din_i,
    input  logic              start_i,
    input  logic              end_i,
    output logic [CRC_W-1:0]  crc_o
);
    typedef struct packed {
        logic             run;
        logic [CRC_W-1:0] acc;
        logic [CRC_W-1:0] res;
    } acc_t;

    acc_t q, d;
    logic [CRC_W-1:0] base, nxt;

    always_comb begin
        d    = q;
        base = start_i ? '0 : q.acc;
        nxt  = crc_step(base, din_i);
        if (start_i || q.run) begin
            d.acc = nxt;
            d.run = !end_i;
            if (end_i) d.res = nxt;
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '0;
        else         q <= d;
    end

    assign crc_o = q.res;

    a_r3_hold_between_ends: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !end_i |=> $stable(crc_o));
endmodule

// File: rtl/edh_pkt_rewriter.sv
module edh_pkt_rewriter
    import edh_crc_pkg::*;
#(
    parameter logic [WORD_W-1:0] EDH_ID = 10'h1F4,
    parameter int unsigned       UDW_N  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WORD_W-1:0] din_i,
    input  logic              ins_n_i,
    input  logic              flag_upd_i,
    input  logic [CRC_W-1:0]  ap_crc_i,
    input  logic [CRC_W-1:0]  ff_crc_i,
    output logic [WORD_W-1:0] dout_o,
    output logic              ap_v_rx_o,
    output logic              ff_v_rx_o
);
    localparam int unsigned IDX_W  = $clog2(UDW_N);
    localparam int unsigned AP_W0  = 0;
    localparam int unsigned FF_W0  = 3;
    localparam int unsigned AP_FLG = 6;
    localparam int unsigned FF_FLG = 7;

    typedef struct packed {
        pkt_state_e        state;
        logic [IDX_W-1:0]  idx;
        logic [SUM_W-1:0]  sum;
        logic [CRC_W-1:0]  rx_ap;
        logic [CRC_W-1:0]  rx_ff;
        logic              ap_v;
        logic              ff_v;
        logic [WORD_W-1:0] dout;
    } rw_t;

    rw_t q, d;
    logic              ins, ap_mm, ff_mm;
    logic [WORD_W-1:0] out;

    always_comb begin
        d     = q;
        ins   = !ins_n_i;
        out   = din_i;
        ap_mm = q.ap_v && (q.rx_ap != ap_crc_i);
        ff_mm = q.ff_v && (q.rx_ff != ff_crc_i);
        unique case (q.state)
            P_IDLE: if (din_i == '0) d.state = P_ADF1;
            P_ADF1: begin
                if (din_i == '1)      d.state = P_ADF2;
                else if (din_i != '0) d.state = P_IDLE;
            end
            P_ADF2: begin
                if (din_i == '1)      d.state = P_DID;
                else if (din_i == '0) d.state = P_ADF1;
                else                  d.state = P_IDLE;
            end
            P_DID: begin
                if (din_i == EDH_ID) begin
                    d.state = P_DBN;
                    d.sum   = din_i[SUM_W-1:0];
                end else if (din_i == '0) d.state = P_ADF1;
                else                      d.state = P_IDLE;
            end
            P_DBN: begin
                d.sum   = q.sum + din_i[SUM_W-1:0];
                d.state = P_DC;
            end
            P_DC: begin
                d.sum   = q.sum + din_i[SUM_W-1:0];
                d.idx   = '0;
                d.state = P_UDW;
            end
            P_UDW: begin
                if (q.idx == IDX_W'(AP_W0)) begin
                    d.rx_ap[SEG_W-1:0] = din_i[7:2];
                    if (ins) out = seal({ap_crc_i[SEG_W-1:0], 2'b00});
                end else if (q.idx == IDX_W'(AP_W0 + 1)) begin
                    d.rx_ap[2*SEG_W-1:SEG_W] = din_i[7:2];
                    if (ins) out = seal({ap_crc_i[2*SEG_W-1:SEG_W], 2'b00});
                end else if (q.idx == IDX_W'(AP_W0 + 2)) begin
                    d.rx_ap[CRC_W-1:2*SEG_W] = din_i[5:2];
                    d.ap_v = din_i[7];
                    if (ins) out = seal({2'b10, ap_crc_i[CRC_W-1:2*SEG_W], 2'b00});
                end else if (q.idx == IDX_W'(FF_W0)) begin
                    d.rx_ff[SEG_W-1:0] = din_i[7:2];
                    if (ins) out = seal({ff_crc_i[SEG_W-1:0], 2'b00});
                end else if (q.idx == IDX_W'(FF_W0 + 1)) begin
                    d.rx_ff[2*SEG_W-1:SEG_W] = din_i[7:2];
                    if (ins) out = seal({ff_crc_i[2*SEG_W-1:SEG_W], 2'b00});
                end else if (q.idx == IDX_W'(FF_W0 + 2)) begin
                    d.rx_ff[CRC_W-1:2*SEG_W] = din_i[5:2];
                    d.ff_v = din_i[7];
                    if (ins) out = seal({2'b10, ff_crc_i[CRC_W-1:2*SEG_W], 2'b00});
                end else if (q.idx == IDX_W'(AP_FLG)) begin
                    if (ins && flag_upd_i)
                        out = seal({din_i[7:4], din_i[3] | din_i[2], ap_mm, din_i[1:0]});
                end else if (q.idx == IDX_W'(FF_FLG)) begin
                    if (ins && flag_upd_i)
                        out = seal({din_i[7:4], din_i[3] | din_i[2], ff_mm, din_i[1:0]});
                end
                d.sum = q.sum + out[SUM_W-1:0];
                d.idx = q.idx + 1'b1;
                if (q.idx == IDX_W'(UDW_N - 1)) d.state = P_CS;
            end
            P_CS: begin
                if (ins) out = {~q.sum[SUM_W-1], q.sum};
                d.state = P_IDLE;
            end
            default: d.state = P_IDLE;
        endcase
        d.dout = out;
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) q <= '{state: P_IDLE, default: '0};
        else         q <= d;
    end

    assign dout_o    = q.dout;
    assign ap_v_rx_o = q.ap_v;
    assign ff_v_rx_o = q.ff_v;

    a_r1_passthru: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ins_n_i |=> (dout_o == $past(din_i)));
    a_r2_outside_packet: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state != P_UDW && q.state != P_CS) |=> (dout_o == $past(din_i)));
    a_r5_valid_forced: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == P_UDW && !ins_n_i &&
         (q.idx == IDX_W'(AP_W0 + 2) || q.idx == IDX_W'(FF_W0 + 2))) |=> dout_o[7]);
    a_r5_crc_parity: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (q.state == P_UDW && !ins_n_i && q.idx < IDX_W'(AP_FLG))
        |=> (dout_o[9] != dout_o[8]) && (dout_o[8] == ^dout_o[7:0]));
    a_r6_ap_status_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(q.state == P_UDW && q.idx == IDX_W'(AP_W0 + 2)) |=> $stable(ap_v_rx_o));
    a_r6_ff_status_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(q.state == P_UDW && q.idx == IDX_W'(FF_W0 + 2)) |=> $stable(ff_v_rx_o));
endmodule

// File: rtl/edh_crc_regen.sv
module edh_crc_regen
    import edh_crc_pkg::*;
#(
    parameter logic [WORD_W-1:0] EDH_ID = 10'h1F4,
    parameter int unsigned       UDW_N  = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic [WORD_W-1:0] din_i,
    input  logic              ap_start_i,
    input  logic              ap_end_i,
    input  logic              ff_start_i,
    input  logic              ff_end_i,
    input  logic              crc_ins_n_i,
    input  logic              flag_upd_i,
    output logic [WORD_W-1:0] dout_o,
    output logic              ap_v_rx_o,
    output logic              ff_v_rx_o
);
    localparam int unsigned N_RANGE = 2;

    logic [N_RANGE-1:0]            rng_start, rng_end;
    logic [N_RANGE-1:0][CRC_W-1:0] rng_crc;

    assign rng_start = {ff_start_i, ap_start_i};
    assign rng_end   = {ff_end_i, ap_end_i};

    for (genvar g = 0; g < N_RANGE; g++) begin : g_acc
        edh_crc_acc u_acc (
            .clk_i   (clk_i),
            .rst_ni  (rst_ni),
            .din_i   (din_i),
            .start_i (rng_start[g]),
            .end_i   (rng_end[g]),
            .crc_o   (rng_crc[g])
        );
    end

    edh_pkt_rewriter #(
        .EDH_ID (EDH_ID),
        .UDW_N  (UDW_N)
    ) u_rw (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .din_i      (din_i),
        .ins_n_i    (crc_ins_n_i),
        .flag_upd_i (flag_upd_i),
        .ap_crc_i   (rng_crc[0]),
        .ff_crc_i   (rng_crc[1]),
        .dout_o     (dout_o),
        .ap_v_rx_o  (ap_v_rx_o),
        .ff_v_rx_o  (ff_v_rx_o)
    );
endmodule

// File: tb/tb_edh_crc_regen.sv
module tb_edh_crc_regen;
    logic       clk = 0;
    logic       rst_n = 0;
    logic [9:0] din = 10'h200;
    logic       aps = 0, ape = 0, ffs = 0, ffe = 0;
    logic       ins_n = 0, upd = 0;
    logic [9:0] dout;
    logic       ap_v, ff_v;

    int checks = 0;
    int errors = 0;

    typedef struct {
        logic [9:0] w;
        string      tag;
    } exp_t;
    exp_t sbq[$];

    logic [15:0] ap_ref = 16'h0;
    logic [15:0] ff_ref = 16'h0;

    always #4 clk = ~clk;

    edh_crc_regen dut (
        .clk_i(clk), .rst_ni(rst_n), .din_i(din),
        .ap_start_i(aps), .ap_end_i(ape), .ff_start_i(ffs), .ff_end_i(ffe),
        .crc_ins_n_i(ins_n), .flag_upd_i(upd),
        .dout_o(dout), .ap_v_rx_o(ap_v), .ff_v_rx_o(ff_v)
    );

    function automatic logic [15:0] m_crc(input logic [15:0] c, input logic [9:0] w);
        logic [15:0] r = c;
        for (int b = 0; b < 10; b++) begin
            if (w[b] ^ r[15]) r = (r << 1) ^ 16'h1021;
            else              r = r << 1;
        end
        return r;
    endfunction

    function automatic logic [9:0] m_seal(input logic [7:0] b);
        logic p = ^b;
        return {~p, p, b};
    endfunction

    task automatic check(input logic [9:0] act, input logic [9:0] exp, input string tag);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic drive(input logic [9:0] w, input logic s_ap, e_ap, s_ff, e_ff,
                         input logic [9:0] exp, input string tag);
        @(negedge clk);
        din = w; aps = s_ap; ape = e_ap; ffs = s_ff; ffe = e_ff;
        sbq.push_back('{exp, tag});
    endtask

    // monitor: one expected word per captured word
    initial begin
        exp_t e;
        @(posedge rst_n);
        forever begin
            @(posedge clk);
            #2;
            if (sbq.size() > 0) begin
                e = sbq.pop_front();
                check(dout, e.w, e.tag);
            end
        end
    end

    task automatic run_field(input int n, input int a0, input int a1,
                             input int f0, input int f1, input int seed);
        logic [15:0] ca = 0, cf = 0;
        for (int i = 0; i < n; i++) begin
            logic [9:0] w;
            w = 10'(10'h040 + ((i * 37 + seed * 13) % 10'h380));
            if (i >= a0 && i <= a1) ca = m_crc((i == a0) ? 16'h0 : ca, w);
            if (i >= f0 && i <= f1) cf = m_crc((i == f0) ? 16'h0 : cf, w);
            drive(w, i == a0, i == a1, i == f0, i == f1, w, "R2 field word");
        end
        ap_ref = ca;
        ff_ref = cf;
    endtask

    function automatic void crc_words(input logic [15:0] c, input logic v,
                                      output logic [9:0] w0, w1, w2);
        w0 = m_seal({c[5:0], 2'b00});
        w1 = m_seal({c[11:6], 2'b00});
        w2 = m_seal({v, 1'b0, c[15:12], 2'b00});
    endfunction

    task automatic send_packet(input logic [9:0] did, input logic [15:0] rx_ap, input logic rx_apv,
                               input logic [15:0] rx_ff, input logic rx_ffv,
                               input logic c_ins_n, input logic c_upd, input string ctag);
        logic [9:0] ui[16];
        logic [9:0] ue[16];
        string      ut[16];
        logic [8:0] s_in, s_ex;
        logic [9:0] cs_in, cs_ex, dbn, dc;
        logic       en;
        logic       amm, fmm;
        dbn = 10'h200;
        dc  = 10'h110;
        en  = !c_ins_n && (did == 10'h1F4);
        crc_words(rx_ap, rx_apv, ui[0], ui[1], ui[2]);
        crc_words(rx_ff, rx_ffv, ui[3], ui[4], ui[5]);
        ui[6] = m_seal(8'b0100_0101);
        ui[7] = m_seal(8'b0011_0000);
        ui[8] = m_seal(8'h1C);
        for (int i = 9; i < 16; i++) ui[i] = m_seal(8'(i * 11));
        for (int i = 0; i < 16; i++) begin
            ue[i] = ui[i];
            ut[i] = en ? "R8 passthrough" : (did == 10'h1F4 ? "R1 disabled" : "R2 foreign packet");
        end
        if (en) begin
            crc_words(ap_ref, 1'b1, ue[0], ue[1], ue[2]);
            crc_words(ff_ref, 1'b1, ue[3], ue[4], ue[5]);
            for (int i = 0; i < 6; i++) ut[i] = {ctag, " R4 crc word"};
            ut[2] = {ctag, " R5 valid word"};
            ut[5] = {ctag, " R5 valid word"};
            if (c_upd) begin
                amm = rx_apv && (rx_ap != ap_ref);
                fmm = rx_ffv && (rx_ff != ff_ref);
                ue[6] = m_seal({ui[6][7:4], ui[6][3] | ui[6][2], amm, ui[6][1:0]});
                ue[7] = m_seal({ui[7][7:4], ui[7][3] | ui[7][2], fmm, ui[7][1:0]});
                ut[6] = "R9 ap flags";
                ut[7] = "R9 ff flags";
            end
        end
        s_in = did[8:0] + dbn[8:0] + dc[8:0];
        s_ex = s_in;
        for (int i = 0; i < 16; i++) begin
            s_in = s_in + ui[i][8:0];
            s_ex = s_ex + ue[i][8:0];
        end
        cs_in = {~s_in[8], s_in};
        cs_ex = en ? {~s_ex[8], s_ex} : cs_in;
        drive(10'h200, 0, 0, 0, 0, 10'h200, "R2 gap");
        ins_n = c_ins_n;
        upd   = c_upd;
        drive(10'h000, 0, 0, 0, 0, 10'h000, "R2 header");
        drive(10'h3FF, 0, 0, 0, 0, 10'h3FF, "R2 header");
        drive(10'h3FF, 0, 0, 0, 0, 10'h3FF, "R2 header");
        drive(did, 0, 0, 0, 0, did, "R2 id");
        drive(dbn, 0, 0, 0, 0, dbn, "R2 block number");
        drive(dc, 0, 0, 0, 0, dc, "R2 count");
        for (int i = 0; i < 16; i++) drive(ui[i], 0, 0, 0, 0, ue[i], ut[i]);
        drive(cs_in, 0, 0, 0, 0, cs_ex, en ? "R7 checksum" : "R1 checksum");
        drive(10'h200, 0, 0, 0, 0, 10'h200, "R2 gap");
        drive(10'h200, 0, 0, 0, 0, 10'h200, "R2 gap");
    endtask

    initial begin
        #800000;
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #22;
        check(dout, 10'h000, "R10 reset dout");
        check({9'h0, ap_v}, 10'h0, "R10 reset ap status");
        check({9'h0, ff_v}, 10'h0, "R10 reset ff status");
        @(negedge clk);
        rst_n = 1;

        // packet before any field: held CRCs are zero
        send_packet(10'h1F4, 16'h1234, 1'b1, 16'hBEEF, 1'b0, 1'b0, 1'b0, "R10");
        check({9'h0, ap_v}, 10'h1, "R6 ap status received");
        check({9'h0, ff_v}, 10'h0, "R6 ff status received");

        // field A, flag update with ap mismatch and ff match
        run_field(200, 40, 150, 0, 199, 1);
        send_packet(10'h1F4, ap_ref ^ 16'h0001, 1'b1, ff_ref, 1'b1, 1'b0, 1'b1, "R3");
        check({9'h0, ap_v}, 10'h1, "R6 ap status received");
        check({9'h0, ff_v}, 10'h1, "R6 ff status received");

        // field B with a one-word active range, no flag update
        run_field(120, 10, 10, 5, 119, 2);
        send_packet(10'h1F4, 16'h0F0F, 1'b0, 16'hA5A5, 1'b0, 1'b0, 1'b0, "R3");
        check({9'h0, ap_v}, 10'h0, "R6 ap status received");
        check({9'h0, ff_v}, 10'h0, "R6 ff status received");

        // field C, insertion disabled
        run_field(80, 0, 79, 20, 60, 3);
        send_packet(10'h1F4, 16'h5555, 1'b1, 16'hAAAA, 1'b0, 1'b1, 1'b1, "R3");
        check({9'h0, ap_v}, 10'h1, "R6 status while disabled");
        check({9'h0, ff_v}, 10'h0, "R6 status while disabled");

        // foreign identifier: untouched, status unchanged
        send_packet(10'h2E0, 16'h7777, 1'b0, 16'h8888, 1'b1, 1'b0, 1'b1, "R2");
        check({9'h0, ap_v}, 10'h1, "R2 R6 status after foreign packet");
        check({9'h0, ff_v}, 10'h0, "R2 R6 status after foreign packet");

        // field D, mismatching CRC but validity low: no error flag
        run_field(60, 5, 50, 0, 59, 4);
        send_packet(10'h1F4, ~ap_ref, 1'b0, ~ff_ref, 1'b0, 1'b0, 1'b1, "R3");

        repeat (4) @(negedge clk);
        if (sbq.size() != 0) begin
            errors++;
            $display("FAIL R2 scoreboard left %0d words actual %0d expected 0", sbq.size(), sbq.size());
        end
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule